// File: doc/BRIEF.md
# Eight-Channel DMA Engine

The block moves data from a source address to a destination address on behalf of up to eight independent channels, sharing one simple memory master port. Each channel holds a source address, a destination address, a 16-bit unit counter and a mode word. A channel is started either by an external request pin or by an internal peripheral interrupt line, chosen per channel. Every transfer unit is one read from the source followed by one write of the same data to the destination. Both addresses then advance by the unit size (1, 2 or 4 bytes).

Four sequencing modes are offered. Step moves one unit per trigger edge. Block moves a programmed number of units per trigger edge. Burst moves the whole remaining count after one edge and keeps the bus the whole time. Continuous moves units for as long as the request level stays high. Channels are arbitrated by fixed priority, and the lowest index wins. Arbitration happens only between units. An asserted NMI or interrupt-hold input stops new units from starting until it clears. When a channel's counter reaches zero, the channel sets a sticky done flag and pulses its interrupt output.

Configuration arrives through a one-cycle write strobe, which addresses a channel and one of its four registers. The sequencer is a state machine with four states:
- `ST_IDLE` waits for a grant.
- `ST_READ` holds a read until it is acknowledged.
- `ST_WRITE` holds the paired write until it is acknowledged.
- `ST_HOLD` parks a burst or block that was interrupted by a pause.

The transitions are as follows:
- IDLE→READ on a grant when no pause is active.
- READ→WRITE on a read acknowledge.
- WRITE→READ when a burst or block has more units and no pause is active.
- WRITE→HOLD when more units remain but a pause is active.
- WRITE→IDLE when the count ends, the block ends, or the mode is step or continuous.
- HOLD→READ when the pause clears.

Top module: `dma8_engine`

## Requirements
- R1: After reset, mem_req is low, and every done_flag and done_irq bit is low.
- R2: A config write selects a register by cfg_sel: 0 is the source address, 1 the destination address, 2 the unit count and 3 the mode word. Mode bits are: bit 0 enable; bit 1 trigger select (0 selects the external pin, 1 the internal interrupt); bits 3:2 unit size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit); bits 5:4 sequence (0 step, 1 block, 2 burst, 3 continuous); bits 15:8 block length. Activity on the unselected trigger input starts nothing.
- R3: In step mode, each rising edge of the selected request moves exactly one unit.
- R4: In block mode, each rising edge moves block-length units, with 0 treated as 1, but never more than the remaining count.
- R5: In burst mode, one rising edge moves the whole remaining count, and mem_req stays high without a gap from the first read to the last write.
- R6: In continuous mode, units are moved while the selected request is high, and none are moved while it is low.
- R7: Source and destination addresses advance by 1, 2 or 4 after each unit, according to the size field. mem_size carries the size code.
- R8: Each unit is a read of the source followed by a write of the read data to the destination. mem_req, mem_we and mem_addr stay stable until mem_ack.
- R9: While nmi or int_hold is high, no new unit starts. A read already issued is completed by its write. Activity resumes when both inputs are low.
- R10: When several channels are ready between units, the lowest channel index is served first.
- R11: When a channel's count reaches zero, its done_flag is set and done_irq pulses for one cycle, and the channel stops. Writing that channel's mode word clears its done_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the config write |
| cfg_sel | input | 2 | Register select: 0 src, 1 dst, 2 count, 3 mode |
| cfg_wdata | input | AW | Configuration write data |
| dreq_ext | input | NCH | External request per channel |
| dreq_int | input | NCH | Internal interrupt request per channel |
| nmi | input | 1 | Non-maskable interrupt pending; pauses transfers |
| int_hold | input | 1 | Interrupt hold; pauses transfers |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Unit size code of the access |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data, right-aligned |
| mem_rdata | input | DW | Read data, right-aligned |
| mem_ack | input | 1 | Access acknowledge |
| done_flag | output | NCH | Sticky per-channel completion flag |
| done_irq | output | NCH | One-cycle completion pulse per channel |

## Verification
Each sequencing mode gets its own stimulus:
- A single step edge tells step apart from block and burst, because exactly one unit may move.
- A single block edge must stop after the programmed length.
- A single burst edge must drain the count with an unbroken request, and the length of that unbroken span tells burst apart from re-arbitrated modes.
- A low and then a high continuous level shows that the level, not an edge, gates the transfers.

Trigger selection is tested by pulsing the unselected input. Priority is tested by triggering two channels in the same cycle. The pause is applied both before a trigger and in the middle of a burst, to tell a clean stop between units from a stop that splits a read from its write.

// File: rtl/dma8_pkg.sv
package dma8_pkg;

    typedef enum logic [1:0] {
        SEQ_STEP  = 2'd0,
        SEQ_BLOCK = 2'd1,
        SEQ_BURST = 2'd2,
        SEQ_CONT  = 2'd3
    } seq_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_HOLD
    } st_e;

    typedef enum logic [1:0] {
        REG_SRC  = 2'd0,
        REG_DST  = 2'd1,
        REG_CNT  = 2'd2,
        REG_MODE = 2'd3
    } reg_e;

    // Mode word as stored (bits 7:6 of the written value are dropped)
    typedef struct packed {
        logic [7:0] blen;
        seq_e       seq;
        logic [1:0] size;
        logic       trig_int;
        logic       en;
    } mode_t;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma8_chan_regs.sv
module dma8_chan_regs
    import dma8_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          adv,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output mode_t         mode,
    output logic          done,
    output logic          done_pulse
);

    logic [AW-1:0] step_amt;
    logic          hits_zero;

    assign step_amt  = AW'(unit_bytes(mode.size));
    assign hits_zero = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src        <= '0;
            dst        <= '0;
            cnt        <= '0;
            mode       <= '0;
            done       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (cfg_we) begin
                unique case (reg_e'(cfg_sel))
                    REG_SRC:  src <= cfg_wdata;
                    REG_DST:  dst <= cfg_wdata;
                    REG_CNT:  cnt <= cfg_wdata[CW-1:0];
                    REG_MODE: begin
                        mode <= mode_t'({cfg_wdata[15:8], cfg_wdata[5:0]});
                        done <= 1'b0;
                    end
                endcase
            end
            if (adv) begin
                src <= src + step_amt;
                dst <= dst + step_amt;
                cnt <= cnt - CW'(1);
                if (hits_zero) begin
                    done       <= 1'b1;
                    done_pulse <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dma8_trig.sv
module dma8_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic req_ext,
    input  logic req_int,
    input  logic use_int,
    input  logic level_mode,
    input  logic armed,
    input  logic take,
    output logic want
);

    logic lvl;
    logic prev;
    logic pend;

    assign lvl  = use_int ? req_int : req_ext;
    assign want = armed && (level_mode ? lvl : pend);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            pend <= 1'b0;
        end else begin
            prev <= lvl;
            if (!armed || level_mode) begin
                pend <= 1'b0;
            end else begin
                pend <= (pend && !take) || (lvl && !prev);
            end
        end
    end

endmodule

// File: rtl/dma8_prio_arb.sv
module dma8_prio_arb #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          vld
);

    always_comb begin
        idx = '0;
        vld = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dma8_engine.sv
module dma8_engine
    import dma8_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic [NCH-1:0]  dreq_ext,
    input  logic [NCH-1:0]  dreq_int,
    input  logic            nmi,
    input  logic            int_hold,
    output logic            mem_req,
    output logic            mem_we,
    output logic [1:0]      mem_size,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic [NCH-1:0]  done_flag,
    output logic [NCH-1:0]  done_irq
);

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    mode_t          mode_a [NCH];
    logic [NCH-1:0] want;
    logic [NCH-1:0] adv;
    logic [NCH-1:0] take;

    // Per-channel register banks and trigger front ends
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma8_chan_regs #(.AW(AW), .CW(CW)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we && (cfg_ch == CHW'(g))),
            .cfg_sel    (cfg_sel),
            .cfg_wdata  (cfg_wdata),
            .adv        (adv[g]),
            .src        (src_a[g]),
            .dst        (dst_a[g]),
            .cnt        (cnt_a[g]),
            .mode       (mode_a[g]),
            .done       (done_flag[g]),
            .done_pulse (done_irq[g])
        );

        dma8_trig u_trig (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_ext    (dreq_ext[g]),
            .req_int    (dreq_int[g]),
            .use_int    (mode_a[g].trig_int),
            .level_mode (mode_a[g].seq == SEQ_CONT),
            .armed      (mode_a[g].en && (cnt_a[g] != '0)),
            .take       (take[g]),
            .want       (want[g])
        );
    end

    logic [CHW-1:0] gidx;
    logic           gvld;

    dma8_prio_arb #(.N(NCH)) u_arb (
        .req (want),
        .idx (gidx),
        .vld (gvld)
    );

    // Sequencer state and per-run context
    st_e            st, st_n;
    logic [CHW-1:0] cur;
    seq_e           seq_cur;
    logic [7:0]     blk_left;
    logic [DW-1:0]  rbuf;

    logic  pause;
    logic  go;
    logic  wr_done;
    logic  last_unit;
    logic  more;
    mode_t cur_mode;

    assign pause     = nmi || int_hold;
    assign go        = (st == ST_IDLE) && gvld && !pause;
    assign wr_done   = (st == ST_WRITE) && mem_ack;
    assign cur_mode  = mode_a[cur];
    assign last_unit = (cnt_a[cur] == CW'(1));
    assign more      = !last_unit &&
                       ((seq_cur == SEQ_BURST) ||
                        ((seq_cur == SEQ_BLOCK) && (blk_left != 8'd0)));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_n;
        end
    end

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: begin
                if (go) st_n = ST_READ;
            end
            ST_READ: begin
                if (mem_ack) st_n = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    if (!more)      st_n = ST_IDLE;
                    else if (pause) st_n = ST_HOLD;
                    else            st_n = ST_READ;
                end
            end
            ST_HOLD: begin
                if (!pause) st_n = ST_READ;
            end
        endcase
    end

    // Run context: granted channel, its sequence, block budget, read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            seq_cur  <= SEQ_STEP;
            blk_left <= '0;
            rbuf     <= '0;
        end else begin
            if (go) begin
                cur      <= gidx;
                seq_cur  <= mode_a[gidx].seq;
                blk_left <= (mode_a[gidx].blen == 8'd0) ? 8'd0
                                                       : mode_a[gidx].blen - 8'd1;
            end
            if ((st == ST_READ) && mem_ack) begin
                rbuf <= mem_rdata;
            end
            if (wr_done && (seq_cur == SEQ_BLOCK) && (blk_left != 8'd0)) begin
                blk_left <= blk_left - 8'd1;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_a[cur];
        mem_size  = (cur_mode.size == 2'd3) ? 2'd2 : cur_mode.size;
        mem_wdata = rbuf;
        adv       = '0;
        take      = '0;
        unique case (st)
            ST_IDLE: begin
                if (go) take = NCH'(1) << gidx;
            end
            ST_READ: begin
                mem_req = 1'b1;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_a[cur];
                if (mem_ack) adv = NCH'(1) << cur;
            end
            ST_HOLD: begin
            end
        endcase
    end

endmodule

// File: rtl/dma8_engine_chk.sv
module dma8_engine_chk #(
    parameter int NCH = 8,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           nmi,
    input logic           int_hold,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic           mem_ack,
    input logic [NCH-1:0] done_flag,
    input logic [NCH-1:0] done_irq
);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R9
    pause_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((nmi || int_hold) && !mem_req) |=> !mem_req);

    // R11
    one_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_irq));

    // R11
    irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_irq) |=> ((done_flag & $past(done_irq)) == $past(done_irq)));

endmodule

bind dma8_engine dma8_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi       (nmi),
    .int_hold  (int_hold),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .done_flag (done_flag),
    .done_irq  (done_irq)
);

// File: tb/sim_dma8_engine.sv
`timescale 1ns/1ps
module sim_dma8_engine;

    localparam int NCH = 8;
    localparam int AW  = 32;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [2:0]     cfg_ch = '0;
    logic [1:0]     cfg_sel = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [NCH-1:0] dreq_ext = '0;
    logic [NCH-1:0] dreq_int = '0;
    logic           nmi = 1'b0;
    logic           int_hold = 1'b0;
    logic           mem_req, mem_we;
    logic [1:0]     mem_size;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata;
    logic           mem_ack;
    logic [NCH-1:0] done_flag, done_irq;

    always #2.5 clk = ~clk;

    dma8_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq_ext(dreq_ext),
        .dreq_int(dreq_int), .nmi(nmi), .int_hold(int_hold),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done_flag(done_flag), .done_irq(done_irq)
    );

    // Memory model, byte array, one wait cycle per access
    logic [7:0] mem [0:1023];
    logic [9:0] ma;
    int nrd = 0, nwr = 0, nirq = 0;
    logic [AW-1:0] last_wr_addr = '0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    assign ma = mem_addr[9:0];
    always_comb begin
        unique case (mem_size)
            2'd0:    mem_rdata = {24'd0, mem[ma]};
            2'd1:    mem_rdata = {16'd0, mem[ma + 10'd1], mem[ma]};
            default: mem_rdata = {mem[ma + 10'd3], mem[ma + 10'd2],
                                  mem[ma + 10'd1], mem[ma]};
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
        end else begin
            nirq <= nirq + $countones(done_irq);
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
            end else begin
                mem_ack <= 1'b0;
                if (mem_ack && mem_req) begin
                    if (mem_we) begin
                        nwr <= nwr + 1;
                        last_wr_addr <= mem_addr;
                        mem[ma] <= mem_wdata[7:0];
                        if (mem_size != 2'd0) mem[ma + 10'd1] <= mem_wdata[15:8];
                        if (mem_size == 2'd2) begin
                            mem[ma + 10'd2] <= mem_wdata[23:16];
                            mem[ma + 10'd3] <= mem_wdata[31:24];
                        end
                    end else begin
                        nrd <= nrd + 1;
                    end
                end
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int mism(input int s, input int d, input int n);
        int m = 0;
        for (int i = 0; i < n; i++) if (mem[d + i] != pat(s + i)) m++;
        return m;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int ch, input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = AW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic arm(input int ch, input int s, input int d, input int n, input int mode);
        cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, n); cfg(ch, 3, mode);
    endtask

    task automatic pulse_ext(input int ch);
        dreq_ext[ch] = 1'b1; cyc(2); dreq_ext[ch] = 1'b0;
    endtask

    task automatic pulse_int(input int ch);
        dreq_int[ch] = 1'b1; cyc(2); dreq_int[ch] = 1'b0;
    endtask

    task automatic t_reset();
        check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        check(done_flag == '0, "R1 done_flag", done_flag, 0);
        check(done_irq == '0, "R1 done_irq", done_irq, 0);
    endtask

    // Step, 32-bit, external trigger on channel 2
    task automatic t_step();
        int w0 = nwr, i0 = nirq;
        arm(2, 'h010, 'h200, 3, 'h09);
        pulse_ext(2); cyc(20);
        check(nwr - w0 == 1, "R3 one unit per edge", nwr - w0, 1);
        check(mism('h010, 'h200, 4) == 0, "R8 data copied", mism('h010, 'h200, 4), 0);
        check(mem['h204] == pat('h204), "R3 next word untouched", mem['h204], pat('h204));
        pulse_ext(2); cyc(20); pulse_ext(2); cyc(20);
        check(nwr - w0 == 3, "R3 three edges", nwr - w0, 3);
        check(mism('h010, 'h200, 12) == 0, "R7 word increment", mism('h010, 'h200, 12), 0);
        check(done_flag[2] == 1'b1, "R11 done flag", done_flag[2], 1);
        check(nirq - i0 == 1, "R11 one irq pulse", nirq - i0, 1);
        pulse_ext(2); cyc(20);
        check(nwr - w0 == 3, "R11 stopped at zero", nwr - w0, 3);
    endtask

    // Block of 2 bytes, internal trigger on channel 3
    task automatic t_block();
        int w0 = nwr;
        arm(3, 'h040, 'h240, 5, 'h213);
        pulse_int(3); cyc(30);
        check(nwr - w0 == 2, "R4 block length", nwr - w0, 2);
        pulse_ext(3); cyc(30);
        check(nwr - w0 == 2, "R2 unselected trigger ignored", nwr - w0, 2);
        pulse_int(3); cyc(30);
        check(nwr - w0 == 4, "R4 second block", nwr - w0, 4);
        check(mism('h040, 'h240, 4) == 0, "R7 byte increment", mism('h040, 'h240, 4), 0);
        check(mem['h244] == pat('h244), "R7 byte past block", mem['h244], pat('h244));
        check(done_flag[3] == 1'b0, "R4 count not drained", done_flag[3], 0);
        pulse_int(3); cyc(30);
        check(nwr - w0 == 5, "R4 clipped by count", nwr - w0, 5);
    endtask

    // Burst of 5 halfwords on channel 4
    task automatic t_burst();
        int w0 = nwr, span = 0, lim = 0;
        arm(4, 'h080, 'h280, 5, 'h25);
        dreq_ext[4] = 1'b1;
        while (!mem_req && lim < 20) begin cyc(1); lim++; end
        while (mem_req && span < 100) begin cyc(1); span++; end
        dreq_ext[4] = 1'b0;
        cyc(10);
        check(span == 20, "R5 unbroken request span", span, 20);
        check(nwr - w0 == 5, "R5 whole count", nwr - w0, 5);
        check(mism('h080, 'h280, 10) == 0, "R7 halfword copy", mism('h080, 'h280, 10), 0);
        check(mem['h28A] == pat('h28A), "R7 halfword bound", mem['h28A], pat('h28A));
        check(done_flag[4] == 1'b1, "R5 done", done_flag[4], 1);
    endtask

    // Continuous, internal level on channel 6
    task automatic t_cont();
        int w0 = nwr;
        arm(6, 'h0C0, 'h2C0, 4, 'h3B);
        cyc(20);
        check(nwr - w0 == 0, "R6 level low idle", nwr - w0, 0);
        dreq_int[6] = 1'b1; cyc(60); dreq_int[6] = 1'b0;
        check(nwr - w0 == 4, "R6 level high moves", nwr - w0, 4);
        check(mism('h0C0, 'h2C0, 16) == 0, "R6 data", mism('h0C0, 'h2C0, 16), 0);
        check(done_flag[6] == 1'b1, "R6 done", done_flag[6], 1);
    endtask

    // Channels 1 and 5 triggered together
    task automatic t_prio();
        int w0 = nwr, lim = 0;
        arm(1, 'h020, 'h300, 1, 'h09);
        arm(5, 'h030, 'h340, 1, 'h09);
        dreq_ext[1] = 1'b1; dreq_ext[5] = 1'b1;
        while (nwr == w0 && lim < 40) begin cyc(1); lim++; end
        check(last_wr_addr == 'h300, "R10 low index first", last_wr_addr, 'h300);
        dreq_ext[1] = 1'b0; dreq_ext[5] = 1'b0;
        cyc(20);
        check(done_flag[1] && done_flag[5], "R10 both served", done_flag, 'h22);
    endtask

    // Pause before a trigger and during a burst, channel 7
    task automatic t_pause();
        int w0 = nwr, r0 = nrd, lim = 0, wmid;
        nmi = 1'b1;
        arm(7, 'h100, 'h380, 6, 'h29);
        pulse_ext(7); cyc(30);
        check(nwr - w0 == 0, "R9 nmi blocks start", nwr - w0, 0);
        check(mem_req == 1'b0, "R9 no request while paused", mem_req, 0);
        nmi = 1'b0; cyc(10); int_hold = 1'b1;
        while (mem_req && lim < 40) begin cyc(1); lim++; end
        wmid = nwr - w0;
        check(nrd - r0 == wmid, "R9 read paired with write", nrd - r0, wmid);
        check(wmid > 0 && wmid < 6, "R9 stopped mid-burst", wmid, 3);
        cyc(30);
        check(nwr - w0 == wmid, "R9 held", nwr - w0, wmid);
        int_hold = 1'b0; cyc(60);
        check(nwr - w0 == 6, "R9 resumed", nwr - w0, 6);
        check(mism('h100, 'h380, 24) == 0, "R9 data", mism('h100, 'h380, 24), 0);
    endtask

    task automatic t_clear();
        cfg(2, 3, 'h08);
        cyc(2);
        check(done_flag[2] == 1'b0, "R11 mode write clears", done_flag[2], 0);
        check(done_flag[4] == 1'b1, "R11 other flag kept", done_flag[4], 1);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_step();
        t_block();
        t_burst();
        t_cont();
        t_prio();
        t_pause();
        t_clear();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule